// File: doc/BRIEF.md
# Stereo ALC and Limiter Gain Controller

This block computes the gain codes for two programmable-gain amplifier channels, left and right. Each channel supplies a level estimate coded as decibels below full scale, and a sample-rate strobe paces the controller. In automatic level control mode the gain goes down while the signal is above a target and goes back up after a quiet period, so the output level is held near the target. In limiter mode the gain only goes down above a threshold, and it recovers no higher than the manually programmed gain.

A channel-select field picks which channels are controlled automatically. A channel that is not selected takes its manual gain code on each strobe. One 4-bit field sets both the target and the threshold. In level-control mode the two highest settings are pulled down to -3 dB, because a target that close to full scale makes the loop misbehave. Three 4-bit fields set the attack, hold and decay periods. Each one scales a base tick, counted in strobes, by a power of two. All configuration comes from an external register file.

Top module: `lvlgain_ctrl`

## Requirements
- R1: `mode_lim`=0 selects level-control mode, in which gain may rise above the manual code up to `gain_max`. `mode_lim`=1 selects limiter mode.
- R2: Channel selection uses `ch_sel`: bit 1 enables automatic control of the left channel and bit 0 that of the right. 00 disables both, 01 controls right only, 10 left only and 11 both. An unselected channel loads its manual code on every strobe.
- R3: `lvl_l` and `lvl_r` give the level as dB of attenuation (value n means -n dBFS). Target code c (0..15) means -(16-c) dB. A channel is above target when its level value is less than 16-c and below target when it is greater. At equality the gain does not change.
- R4: In level-control mode, codes 14 and 15 behave as -3 dB (attenuation 3). In limiter mode they keep -2 dB and -1 dB.
- R5: While a channel is above target, its gain falls by one code every A strobes, where A = TICK_BASE << `atk_fld`. The first step lands on the A-th consecutive strobe above target.
- R6: When a channel drops below target, its gain is held for H = TICK_BASE << `hold_fld` strobes. It then rises by one code every D = TICK_BASE << `dcy_fld` strobes, so the first rise lands on strobe H+D.
- R7: A strobe that finds the level at or above target ends any hold or decay. The next strobe below target starts a fresh hold count.
- R8: An automatically controlled gain stays within [`gain_min`, `gain_max`] in level-control mode. In limiter mode it stays within [`gain_min`, min(`gain_max`, manual)].
- R9: In limiter mode the gain recovers toward the manual code and never goes above it. A gain above the manual code is pulled down to it on the next strobe.
- R10: The gain outputs change only on clock edges where `smp_stb` is high.
- R11: After reset both gain outputs are 0 and all timers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample-rate strobe; advances timers and gain |
| mode_lim | input | 1 | 0 = level control, 1 = limiter |
| ch_sel | input | 2 | Automatic channel enables (bit 1 left, bit 0 right) |
| tgt_code | input | TGT_W | Target / threshold code |
| atk_fld | input | FLD_W | Attack period exponent |
| hold_fld | input | FLD_W | Hold period exponent |
| dcy_fld | input | FLD_W | Decay period exponent |
| gain_min | input | GAIN_W | Lowest permitted gain code |
| gain_max | input | GAIN_W | Highest permitted gain code |
| man_gain_l | input | GAIN_W | Manual gain code, left |
| man_gain_r | input | GAIN_W | Manual gain code, right |
| lvl_l | input | LVL_W | Level estimate, left, dB below full scale |
| lvl_r | input | LVL_W | Level estimate, right, dB below full scale |
| gain_l | output | GAIN_W | Gain code, left |
| gain_r | output | GAIN_W | Gain code, right |

## Verification
The hardest case to reach from the ports is a hold that is cut short by one strobe above target when only part of the hold window has passed. The bench has to prove that the hold count restarts rather than carries on. It gets there by first loading a known gain with the function disabled, which also clears each channel's phase. It then issues exact strobe counts around a long attack period, so that the single strobe above target does not itself change the gain. The ALC clamp is checked by pairing code 14 with a level of 2 dB: the attack step happens only if the clamp is applied.

// File: rtl/lvlgain_pkg.sv
// Shared constants and types for the stereo gain controller.
// Assumes two channels; index CH_L is left and CH_R is right.
package lvlgain_pkg;
    localparam int NCH         = 2;
    localparam int CH_L        = 0;
    localparam int CH_R        = 1;
    // Lowest attenuation (dB) a level-control target may request.
    localparam int ALC_MIN_ATT = 3;

    // Per-channel timing phase.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ATK   = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DECAY = 2'd3
    } phase_e;
endpackage

// File: rtl/lvlgain_cfg.sv
// Configuration decode: turns the target code into an attenuation
// (applying the level-control floor), decodes the channel-select field
// into per-channel enables and forms each channel's upper gain bound.
// Assumes all inputs are static relative to the strobe rate.
module lvlgain_cfg
    import lvlgain_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int LVL_W  = 7,
    parameter int TGT_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mode_lim,
    input  logic [NCH-1:0]               ch_sel,
    input  logic [TGT_W-1:0]             tgt_code,
    input  logic [GAIN_W-1:0]            gain_max,
    input  logic [NCH-1:0][GAIN_W-1:0]   man_v,
    output logic [NCH-1:0]               auto_en,
    output logic [LVL_W-1:0]             tgt_att,
    output logic [NCH-1:0][GAIN_W-1:0]   ceil_v
);
    localparam int TGT_SPAN = 1 << TGT_W;

    logic [LVL_W-1:0] raw_att;

    // Map the code to attenuation and apply the level-control floor.
    always_comb begin
        raw_att = LVL_W'(TGT_SPAN) - LVL_W'(tgt_code);
        if (!mode_lim && (raw_att < LVL_W'(ALC_MIN_ATT)))
            tgt_att = LVL_W'(ALC_MIN_ATT);
        else
            tgt_att = raw_att;
    end

    // Channel-select decode: bit 1 drives left, bit 0 drives right.
    assign auto_en[CH_L] = ch_sel[1];
    assign auto_en[CH_R] = ch_sel[0];

    // Upper bound per channel: limiter never exceeds the manual code.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ceil
        assign ceil_v[ch] = (mode_lim && (man_v[ch] < gain_max)) ? man_v[ch] : gain_max;
    end

    AST_ALC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n) (!mode_lim) |-> (tgt_att >= LVL_W'(ALC_MIN_ATT))); // R4
endmodule

// File: rtl/lvlgain_det.sv
// Level comparator: classifies a channel's level against the target
// attenuation. A larger attenuation value means a quieter signal.
// Assumes level and target share the same dB-per-LSB scale.
module lvlgain_det #(
    parameter int LVL_W = 7
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] tgt_att,
    output logic             above,
    output logic             below
);
    // Louder than target when attenuation is smaller.
    always_comb begin
        above = (lvl < tgt_att);
        below = (lvl > tgt_att);
    end
endmodule

// File: rtl/lvlgain_chan.sv
// One channel's attack/hold/decay engine and gain register.
// On each strobe it either loads the manual code (channel not enabled)
// or steps the gain by the timing rules, then clamps to [gmin, ceil].
// Assumes gmin <= ceil for the bound to be meaningful; if not, gmin wins.
module lvlgain_chan
    import lvlgain_pkg::*;
#(
    parameter int GAIN_W    = 6,
    parameter int FLD_W     = 4,
    parameter int TICK_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              auto_en,
    input  logic              above,
    input  logic              below,
    input  logic [FLD_W-1:0]  atk_fld,
    input  logic [FLD_W-1:0]  hold_fld,
    input  logic [FLD_W-1:0]  dcy_fld,
    input  logic [GAIN_W-1:0] gmin,
    input  logic [GAIN_W-1:0] ceil,
    input  logic [GAIN_W-1:0] man,
    output logic [GAIN_W-1:0] gain
);
    localparam int CNT_W = $clog2(TICK_BASE + 1) + (1 << FLD_W);

    phase_e             phase_q, ph_req, ph_nxt;
    logic [CNT_W-1:0]   cnt_q, cnt_base, cnt_inc, cnt_nxt;
    logic [CNT_W-1:0]   per_atk, per_hold, per_dcy, per_sel;
    logic               expire;
    logic [GAIN_W-1:0]  gain_q, raw_gain, hi_lim, gain_nxt;

    // Period lengths in strobes for each timing field.
    always_comb begin
        per_atk  = CNT_W'(TICK_BASE) << atk_fld;
        per_hold = CNT_W'(TICK_BASE) << hold_fld;
        per_dcy  = CNT_W'(TICK_BASE) << dcy_fld;
    end

    // Requested phase from the level class; decay persists while below.
    always_comb begin
        if (above)
            ph_req = PH_ATK;
        else if (below)
            ph_req = ((phase_q == PH_HOLD) || (phase_q == PH_DECAY)) ? phase_q : PH_HOLD;
        else
            ph_req = PH_IDLE;
    end

    // Strobe counter: restarts on phase change, flags period completion.
    always_comb begin
        case (ph_req)
            PH_ATK:   per_sel = per_atk;
            PH_HOLD:  per_sel = per_hold;
            PH_DECAY: per_sel = per_dcy;
            default:  per_sel = '0;
        endcase
        cnt_base = (ph_req == phase_q) ? cnt_q : '0;
        cnt_inc  = cnt_base + CNT_W'(1);
        expire   = (ph_req != PH_IDLE) && (cnt_inc >= per_sel);
    end

    // Phase transition and single-code gain step.
    always_comb begin
        ph_nxt   = ph_req;
        cnt_nxt  = expire ? '0 : cnt_inc;
        raw_gain = gain_q;
        case (ph_req)
            PH_ATK: begin
                if (expire && (gain_q != '0))
                    raw_gain = gain_q - GAIN_W'(1);
            end
            PH_HOLD: begin
                if (expire)
                    ph_nxt = PH_DECAY;
            end
            PH_DECAY: begin
                if (expire && (gain_q != '1))
                    raw_gain = gain_q + GAIN_W'(1);
            end
            default: cnt_nxt = '0;
        endcase
    end

    // Bound the stepped gain: upper limit first, floor has priority.
    always_comb begin
        hi_lim   = (raw_gain > ceil) ? ceil : raw_gain;
        gain_nxt = (hi_lim < gmin) ? gmin : hi_lim;
    end

    // State register: updates only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q  <= '0;
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (stb) begin
            if (auto_en) begin
                gain_q  <= gain_nxt;
                phase_q <= ph_nxt;
                cnt_q   <= cnt_nxt;
            end else begin
                gain_q  <= man;
                phase_q <= PH_IDLE;
                cnt_q   <= '0;
            end
        end
    end

    assign gain = gain_q;

    AST_GAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!stb) |=> $stable(gain_q)); // R10
    AST_GAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (stb && auto_en && (gmin <= ceil)) |=> ((gain_q >= $past(gmin)) && (gain_q <= $past(ceil)))); // R8
    AST_ATK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) (stb && auto_en && above && (gain_q >= gmin)) |=> (gain_q <= $past(gain_q))); // R5
    AST_DECAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n) (stb && auto_en && below && (gain_q >= gmin) && (gain_q <= ceil)) |=> ({1'b0, gain_q} <= ({1'b0, $past(gain_q)} + 1'b1))); // R6
endmodule

// File: rtl/lvlgain_ctrl.sv
// Top of the stereo level-control / limiter gain engine. Wires the
// configuration decode, one level comparator and one timing channel per
// amplifier. Assumes level inputs are already in dB-below-full-scale form
// and that the strobe is at most one cycle wide per sample.
module lvlgain_ctrl
    import lvlgain_pkg::*;
#(
    parameter int GAIN_W    = 6,
    parameter int LVL_W     = 7,
    parameter int TGT_W     = 4,
    parameter int FLD_W     = 4,
    parameter int TICK_BASE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              mode_lim,
    input  logic [1:0]        ch_sel,
    input  logic [TGT_W-1:0]  tgt_code,
    input  logic [FLD_W-1:0]  atk_fld,
    input  logic [FLD_W-1:0]  hold_fld,
    input  logic [FLD_W-1:0]  dcy_fld,
    input  logic [GAIN_W-1:0] gain_min,
    input  logic [GAIN_W-1:0] gain_max,
    input  logic [GAIN_W-1:0] man_gain_l,
    input  logic [GAIN_W-1:0] man_gain_r,
    input  logic [LVL_W-1:0]  lvl_l,
    input  logic [LVL_W-1:0]  lvl_r,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r
);
    logic [NCH-1:0][GAIN_W-1:0] man_v, ceil_v, gain_v;
    logic [NCH-1:0][LVL_W-1:0]  lvl_v;
    logic [NCH-1:0]             auto_en, above_v, below_v;
    logic [LVL_W-1:0]           tgt_att;

    // Pack the per-channel ports into indexed vectors.
    assign man_v[CH_L] = man_gain_l;
    assign man_v[CH_R] = man_gain_r;
    assign lvl_v[CH_L] = lvl_l;
    assign lvl_v[CH_R] = lvl_r;

    lvlgain_cfg #(
        .GAIN_W (GAIN_W),
        .LVL_W  (LVL_W),
        .TGT_W  (TGT_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_lim (mode_lim),
        .ch_sel   (ch_sel),
        .tgt_code (tgt_code),
        .gain_max (gain_max),
        .man_v    (man_v),
        .auto_en  (auto_en),
        .tgt_att  (tgt_att),
        .ceil_v   (ceil_v)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        lvlgain_det #(
            .LVL_W (LVL_W)
        ) det_i (
            .lvl     (lvl_v[ch]),
            .tgt_att (tgt_att),
            .above   (above_v[ch]),
            .below   (below_v[ch])
        );

        lvlgain_chan #(
            .GAIN_W    (GAIN_W),
            .FLD_W     (FLD_W),
            .TICK_BASE (TICK_BASE)
        ) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb      (smp_stb),
            .auto_en  (auto_en[ch]),
            .above    (above_v[ch]),
            .below    (below_v[ch]),
            .atk_fld  (atk_fld),
            .hold_fld (hold_fld),
            .dcy_fld  (dcy_fld),
            .gmin     (gain_min),
            .ceil     (ceil_v[ch]),
            .man      (man_v[ch]),
            .gain     (gain_v[ch])
        );
    end

    assign gain_l = gain_v[CH_L];
    assign gain_r = gain_v[CH_R];

    AST_LIM_CEIL_L: assert property (@(posedge clk) disable iff (!rst_n) (smp_stb && mode_lim && ch_sel[1] && (gain_min <= man_gain_l)) |=> (gain_l <= $past(man_gain_l))); // R9
    AST_LIM_CEIL_R: assert property (@(posedge clk) disable iff (!rst_n) (smp_stb && mode_lim && ch_sel[0] && (gain_min <= man_gain_r)) |=> (gain_r <= $past(man_gain_r))); // R9
    AST_MAN_ROUTE_L: assert property (@(posedge clk) disable iff (!rst_n) (smp_stb && !ch_sel[1]) |=> (gain_l == $past(man_gain_l))); // R2
    AST_MAN_ROUTE_R: assert property (@(posedge clk) disable iff (!rst_n) (smp_stb && !ch_sel[0]) |=> (gain_r == $past(man_gain_r))); // R2
endmodule

// File: tb/lvlgain_ctrl_tb_top.sv
// Directed bench for lvlgain_ctrl: one task per scenario, each checking itself.
module lvlgain_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       mode_lim = 1'b0;
    logic [1:0] ch_sel = 2'b00;
    logic [3:0] tgt_code = 4'd10;
    logic [3:0] atk_fld = 4'd0;
    logic [3:0] hold_fld = 4'd0;
    logic [3:0] dcy_fld = 4'd0;
    logic [5:0] gain_min = 6'd0;
    logic [5:0] gain_max = 6'd63;
    logic [5:0] man_gain_l = 6'd0;
    logic [5:0] man_gain_r = 6'd0;
    logic [6:0] lvl_l = 7'd20;
    logic [6:0] lvl_r = 7'd20;
    logic [5:0] gain_l, gain_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvlgain_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .mode_lim   (mode_lim),
        .ch_sel     (ch_sel),
        .tgt_code   (tgt_code),
        .atk_fld    (atk_fld),
        .hold_fld   (hold_fld),
        .dcy_fld    (dcy_fld),
        .gain_min   (gain_min),
        .gain_max   (gain_max),
        .man_gain_l (man_gain_l),
        .man_gain_r (man_gain_r),
        .lvl_l      (lvl_l),
        .lvl_r      (lvl_r),
        .gain_l     (gain_l),
        .gain_r     (gain_r)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One strobe; returns at the falling edge after the capturing edge.
    task automatic strobe(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) smp_stb = 1'b1;
            @(negedge clk) smp_stb = 1'b0;
        end
    endtask

    // Load both gains through the disabled path, which also clears phases.
    task automatic preload(input int gl, input int gr);
        ch_sel = 2'b00;
        man_gain_l = 6'(gl);
        man_gain_r = 6'(gr);
        strobe();
        chk("R2 preload left manual", gain_l, gl);
        chk("R2 preload right manual", gain_r, gr);
    endtask

    task automatic t_reset();
        chk("R11 reset gain_l", gain_l, 0);
        chk("R11 reset gain_r", gain_r, 0);
    endtask

    task automatic t_manual();
        preload(20, 33);
        man_gain_l = 6'd5;
        repeat (4) @(negedge clk);
        chk("R10 no strobe no change", gain_l, 20);
        strobe();
        chk("R10 manual after strobe", gain_l, 5);
    endtask

    task automatic t_attack();
        preload(40, 40);
        mode_lim = 1'b0; ch_sel = 2'b11; tgt_code = 4'd10;
        atk_fld = 4'd1; hold_fld = 4'd3; lvl_l = 7'd2; lvl_r = 7'd6;
        strobe(); chk("R5 attack strobe1", gain_l, 40);
        chk("R3 at target no change", gain_r, 40);
        strobe(); chk("R5 attack strobe2", gain_l, 39);
        strobe(); chk("R5 attack strobe3", gain_l, 39);
        strobe(); chk("R5 attack strobe4", gain_l, 38);
        lvl_r = 7'd7;
        strobe(); chk("R5 attack strobe5", gain_l, 38);
        chk("R3 just below target no attack", gain_r, 40);
    endtask

    task automatic t_decay();
        lvl_l = 7'd20; hold_fld = 4'd2; dcy_fld = 4'd0;
        strobe(4); chk("R6 held through hold period", gain_l, 38);
        strobe(); chk("R6 first decay step", gain_l, 39);
        strobe(); chk("R6 second decay step", gain_l, 40);
    endtask

    task automatic t_hold_restart();
        preload(40, 40);
        mode_lim = 1'b0; ch_sel = 2'b11; tgt_code = 4'd10;
        atk_fld = 4'd3; hold_fld = 4'd2; dcy_fld = 4'd0; lvl_l = 7'd20;
        strobe(3);
        lvl_l = 7'd2; strobe();
        chk("R7 short above strobe no step", gain_l, 40);
        lvl_l = 7'd20; strobe(3);
        chk("R7 hold restarted", gain_l, 40);
        strobe(); chk("R7 hold expires", gain_l, 40);
        strobe(); chk("R7 decay after restart", gain_l, 41);
        lvl_l = 7'd2; strobe();
        lvl_l = 7'd20; strobe();
        chk("R7 decay ended by above strobe", gain_l, 41);
    endtask

    task automatic t_clamp();
        preload(30, 30);
        mode_lim = 1'b0; ch_sel = 2'b11; atk_fld = 4'd0; hold_fld = 4'd3;
        lvl_r = 7'd20;
        tgt_code = 4'd15; lvl_l = 7'd2; strobe();
        chk("R4 code 15 clamped in ALC", gain_l, 29);
        tgt_code = 4'd14; strobe();
        chk("R4 code 14 clamped in ALC", gain_l, 28);
        tgt_code = 4'd13; lvl_l = 7'd3; strobe();
        chk("R4 code 13 at -3 dB equal", gain_l, 28);
        mode_lim = 1'b1; tgt_code = 4'd15; lvl_l = 7'd2; strobe();
        chk("R4 limiter keeps -1 dB", gain_l, 28);
        lvl_l = 7'd0; strobe();
        chk("R4 limiter above -1 dB attacks", gain_l, 27);
        mode_lim = 1'b0;
    endtask

    task automatic t_bounds();
        preload(38, 38);
        mode_lim = 1'b0; ch_sel = 2'b11; tgt_code = 4'd10; gain_max = 6'd41;
        hold_fld = 4'd0; dcy_fld = 4'd0; atk_fld = 4'd0;
        lvl_l = 7'd20; lvl_r = 7'd20;
        strobe(2); chk("R8 decay under ceiling", gain_l, 39);
        strobe(8); chk("R8 left stops at gain_max", gain_l, 41);
        chk("R8 right stops at gain_max", gain_r, 41);
        gain_min = 6'd35; lvl_l = 7'd0; lvl_r = 7'd0;
        strobe(10); chk("R8 left stops at gain_min", gain_l, 35);
        chk("R8 right stops at gain_min", gain_r, 35);
        gain_min = 6'd0; gain_max = 6'd63;
    endtask

    task automatic t_limiter();
        preload(30, 30);
        mode_lim = 1'b1; ch_sel = 2'b11; tgt_code = 4'd10;
        atk_fld = 4'd0; hold_fld = 4'd0; dcy_fld = 4'd0;
        lvl_l = 7'd0; lvl_r = 7'd20;
        strobe(2); chk("R9 limiter attack", gain_l, 28);
        lvl_l = 7'd20;
        strobe(3); chk("R9 limiter recovers to manual", gain_l, 30);
        strobe(3); chk("R9 limiter stays at manual", gain_l, 30);
        mode_lim = 1'b0;
        strobe(6); chk("R1 ALC rises past manual", gain_l, 36);
        mode_lim = 1'b1;
        strobe(); chk("R9 limiter pulls down to manual", gain_l, 30);
        mode_lim = 1'b0;
    endtask

    task automatic t_route();
        preload(30, 30);
        mode_lim = 1'b0; tgt_code = 4'd10; atk_fld = 4'd0;
        lvl_l = 7'd0; lvl_r = 7'd0;
        ch_sel = 2'b01; man_gain_l = 6'd12; strobe();
        chk("R2 sel 01 left manual", gain_l, 12);
        chk("R2 sel 01 right automatic", gain_r, 29);
        ch_sel = 2'b10; man_gain_r = 6'd50; strobe();
        chk("R2 sel 10 left automatic", gain_l, 11);
        chk("R2 sel 10 right manual", gain_r, 50);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_manual();
        t_attack();
        t_decay();
        t_hold_restart();
        t_clamp();
        t_bounds();
        t_limiter();
        t_route();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule